// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked host to an asynchronous static RAM of 131,072 words by 8 bits. The host hands over one word access at a time with a request strobe, a write flag, an address and write data. The controller drives the strobe sequence the memory needs, using active-low chip enable, output enable and write enable. It returns a one-cycle completion pulse, together with the captured read data on reads. The memory needs no clock and no refresh, so every timing constraint becomes a number of clock cycles that the controller waits.

When an access is accepted, the address and write data are latched. Reads hold chip enable and output enable low for a parameterised access window. The bus value is registered on the edge that ends that window, and both strobes are released in the completion cycle. Writes first set up the address with only chip enable low. Write enable then pulses low for a parameterised width while the controller drives the data. One hold cycle follows with write enable high and data still driven. The sequence ends with a deselected turnaround gap before the next access can start. Output enable stays high for the whole write, so the shorter write-pulse rule applies and the two sides never drive the bus together. Requests that arrive while an access is in progress are dropped.

Top module: `asram_ctrl`

## Requirements
- R1: During and straight after reset, chip enable, output enable and write enable are all high (inactive), the data drive enable is low, the done pulse is low and the read data register is zero.
- R2: A read holds chip enable low, output enable low and write enable high, with the data drive enable low, for RD_WAIT cycles. The next cycle has both enables high, done high for exactly one cycle, and read data equal to the word the memory presented at that address.
- R3: Counting the cycle in which the request is sampled as cycle 0, read done appears in cycle RD_WAIT+1.
- R4: A write keeps output enable high throughout. It shows chip enable low with write enable high for WR_SETUP cycles, then write enable low for WR_PULSE cycles, then one cycle with write enable high and chip enable still low. Write enable is never low while chip enable is high.
- R5: The data drive enable is high in every cycle where write enable is low and in the one cycle after write enable rises, it is never high while output enable is low, and the driven value is the latched write data.
- R6: The memory address equals the latched request address, and it does not change in any cycle where chip enable stays low.
- R7: After the write hold cycle, chip enable is high and drive enable low for TURN_GAP cycles, and done is high, for one cycle only, in the last of them. Write done therefore appears in cycle WR_SETUP+WR_PULSE+TURN_GAP+1.
- R8: A request raised while an access is in progress is ignored: no extra strobe activity, no extra done pulse, and the memory word it names keeps its earlier value.
- R9: With no request pending, chip enable stays high and no strobe toggles.
- R10: The read data output changes only together with a read done pulse and keeps its value across later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address of the access |
| req_wdata | input | 8 | Data to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last word read |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Value to drive onto the data bus |
| mem_dq_in | input | 8 | Value sensed on the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable, active high |

## Verification
A fixed list of accesses is run first. It writes both ends of the address range, reads them back in a different order, reads a word that was never written (its content depends on the address), and overwrites a word and reads it again. These accesses separate address latching and write commit from the read capture path. Every cycle of every access is compared with a per-cycle expected strobe pattern, so a wrong wait count, a missing hold cycle or a misplaced done pulse shows up as a mismatch at a known offset. A memory model tracks output-enable and write-enable overlap, bus contention and address movement under chip enable. Directed cases then cover a request injected in the middle of a write, an idle stretch, and whether read data survives a later write.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURNAROUND
    } asram_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } asram_strobe_t;

    // Bits needed to hold a down-count starting at n-1 (at least one bit).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Strobe levels for each sequencer state.
    function automatic asram_strobe_t strobe_of(input asram_state_e s);
        asram_strobe_t r;
        r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_RD_ACCESS: begin
                r.ce_n = 1'b0;
                r.oe_n = 1'b0;
            end
            ST_WR_SETUP: r.ce_n = 1'b0;
            ST_WR_PULSE: begin
                r.ce_n  = 1'b0;
                r.we_n  = 1'b0;
                r.drive = 1'b1;
            end
            ST_WR_HOLD: begin
                r.ce_n  = 1'b0;
                r.drive = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned WR_SETUP = 1,
    parameter int unsigned WR_PULSE = 1,
    parameter int unsigned RD_WAIT  = 2,
    parameter int unsigned TURN_GAP = 1,
    parameter int unsigned CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output asram_state_e     state,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             accept,
    output logic             capture,
    output logic             done
);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(WR_SETUP - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(WR_PULSE - 1);
    localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_GAP - 1);

    asram_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    cnt_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                        cnt_val = SETUP_LD;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        cnt_val = READ_LD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (expired) begin
                    capture = 1'b1;
                    state_d = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (expired) begin
                    state_d  = ST_WR_PULSE;
                    cnt_load = 1'b1;
                    cnt_val  = PULSE_LD;
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                state_d  = ST_TURNAROUND;
                cnt_load = 1'b1;
                cnt_val  = TURN_LD;
            end
            ST_TURNAROUND: begin
                if (expired) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned WR_SETUP = 1,
    parameter int unsigned WR_PULSE = 1,
    parameter int unsigned RD_WAIT  = 2,
    parameter int unsigned TURN_GAP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned MAX_WAIT =
        max2(max2(WR_SETUP, WR_PULSE), max2(RD_WAIT, TURN_GAP));
    localparam int unsigned CNT_W = cnt_bits(MAX_WAIT);

    asram_state_e     state;
    asram_strobe_t    strb;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             expired;
    logic             accept;
    logic             capture;

    asram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (expired)
    );

    asram_seq #(
        .WR_SETUP (WR_SETUP),
        .WR_PULSE (WR_PULSE),
        .RD_WAIT  (RD_WAIT),
        .TURN_GAP (TURN_GAP),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .state     (state),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .accept    (accept),
        .capture   (capture),
        .done      (rsp_done)
    );

    asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .capture  (capture),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .bus_in   (mem_dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rdata_q  (rsp_rdata)
    );

    assign strb      = strobe_of(state);
    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.drive;
endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R4
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n); // R4
    AST_DRIVE_DURING_WE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe); // R5
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe); // R5
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R7
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (mem_ce_n && !mem_dq_oe)); // R2
    AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rsp_rdata) |-> rsp_done); // R10
endmodule

bind asram_ctrl asram_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int SETUP = 2;
    localparam int PULSE = 3;
    localparam int RWAIT = 2;
    localparam int TURN  = 2;
    localparam int LAT_RD = RWAIT + 1;
    localparam int LAT_WR = SETUP + PULSE + TURN + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    asram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .WR_SETUP(SETUP), .WR_PULSE(PULSE),
        .RD_WAIT(RWAIT), .TURN_GAP(TURN)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // ---------------- behavioural memory ----------------
    logic [DW-1:0] model_mem [int unsigned];
    logic [DW-1:0] shadow    [int unsigned];

    function automatic logic [DW-1:0] blank(input logic [AW-1:0] a);
        return a[7:0] ^ {a[16], a[15:9]} ^ 8'h5A;
    endfunction

    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
        if (model_mem.exists(int'(a))) return model_mem[int'(a)];
        return blank(a);
    endfunction

    function automatic logic [DW-1:0] shadow_rd(input logic [AW-1:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return blank(a);
    endfunction

    always @* begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) mem_dq_in = model_rd(mem_addr);
        else mem_dq_in = 8'h00;
    end

    logic prev_we = 1'b1;
    logic prev_ce = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    int ce_low_cycles = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n && !mem_oe_n) begin viol++; $display("violation: WE and OE both low"); end
            if (mem_dq_oe && !mem_oe_n) begin viol++; $display("violation: bus contention"); end
            if (!mem_we_n && !mem_dq_oe) begin viol++; $display("violation: WE low, data undriven"); end
            if (!mem_we_n && mem_ce_n) begin viol++; $display("violation: WE low while deselected"); end
            if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) begin
                viol++; $display("violation: address moved under CE");
            end
            if (!prev_we && mem_we_n && !mem_ce_n) begin
                if (!mem_dq_oe) begin viol++; $display("violation: no data hold after WE"); end
                model_mem[int'(mem_addr)] = mem_dq_out;
            end
            if (!mem_ce_n) ce_low_cycles++;
        end
        prev_we   = mem_we_n;
        prev_ce   = mem_ce_n;
        prev_addr = mem_addr;
    end

    // ---------------- check helper ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Runs one access and compares every cycle with the expected pattern.
    // inject: raise a second request in the middle of the access.
    task automatic run_txn(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit inject, input logic [AW-1:0] ia);
        int lat;
        int bad_seq;
        int bad_addr;
        int bad_done;
        logic [3:0] exp_s, act_s;
        logic [DW-1:0] exp_rd;
        lat = wr ? LAT_WR : LAT_RD;
        bad_seq = 0; bad_addr = 0; bad_done = 0;
        exp_rd = shadow_rd(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (inject && k == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = ia; req_wdata = ~d;
            end
            // expected {ce_n, oe_n, we_n, drive}
            if (wr) begin
                if (k <= SETUP) exp_s = 4'b0110;
                else if (k <= SETUP + PULSE) exp_s = 4'b0101;
                else if (k == SETUP + PULSE + 1) exp_s = 4'b0111;
                else exp_s = 4'b1110;
            end else begin
                exp_s = (k <= RWAIT) ? 4'b0010 : 4'b1110;
            end
            act_s = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
            if (act_s != exp_s) begin
                bad_seq++;
                $display("  offset %0d strobes %b expected %b", k, act_s, exp_s);
            end
            if (!mem_ce_n && mem_addr != a) bad_addr++;
            if (mem_dq_oe && mem_dq_out != d) bad_addr++;
            if (rsp_done != (k == lat)) bad_done++;
        end
        if (wr) begin
            check(bad_seq == 0, "R4 write strobe sequence", bad_seq, 0);
            check(bad_done == 0, "R7 write done position", bad_done, 0);
            shadow[int'(a)] = d;
        end else begin
            check(bad_seq == 0, "R2 read strobe sequence", bad_seq, 0);
            check(bad_done == 0, "R3 read done position", bad_done, 0);
            check(rsp_rdata == exp_rd, "R2 read data", rsp_rdata, exp_rd);
        end
        check(bad_addr == 0, "R6 address/data under CE", bad_addr, 0);
        @(negedge clk);
        check(!rsp_done && mem_ce_n, "R7 back to idle after done", {rsp_done, mem_ce_n}, 2'b01);
        req_valid = 1'b0;
    endtask

    // ---------------- stimulus table: {write, addr, data} ----------------
    localparam int NVEC = 9;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 17'h00000, 8'h55},
        {1'b1, 17'h1FFFF, 8'hAA},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b0, 17'h00000, 8'h00},
        {1'b1, 17'h0ABCD, 8'h3C},
        {1'b0, 17'h0ABCD, 8'h00},
        {1'b0, 17'h12345, 8'h00},
        {1'b1, 17'h1FFFF, 8'h0F},
        {1'b0, 17'h1FFFF, 8'h00}
    };

    initial begin
        int ce_before;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done} == 5'b11100,
              "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done} == 5'b11100,
              "R1 strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_done}, 5'b11100);
        check(rsp_rdata == 8'h00, "R1 read data reset", rsp_rdata, 0);

        // R9 idle: no activity without requests
        ce_before = ce_low_cycles;
        repeat (6) @(negedge clk);
        check(ce_low_cycles == ce_before && mem_we_n && mem_oe_n, "R9 idle strobes",
              ce_low_cycles - ce_before, 0);

        for (int i = 0; i < NVEC; i++) begin
            run_txn(VEC[i][25], VEC[i][24:8], VEC[i][7:0], 1'b0, '0);
        end

        // R8: request during a write is dropped
        run_txn(1'b1, 17'h00777, 8'hC3, 1'b1, 17'h00999);
        ce_before = ce_low_cycles;
        repeat (4) @(negedge clk);
        check(ce_low_cycles == ce_before, "R8 no extra access after busy request",
              ce_low_cycles - ce_before, 0);
        run_txn(1'b0, 17'h00999, 8'h00, 1'b0, '0);
        check(rsp_rdata == blank(17'h00999), "R8 dropped write left memory alone",
              rsp_rdata, blank(17'h00999));

        // R10: read data survives a write
        held = rsp_rdata;
        run_txn(1'b1, 17'h00010, 8'h99, 1'b0, '0);
        check(rsp_rdata == held, "R10 read data held over write", rsp_rdata, held);

        // R5 protocol monitor summary
        check(viol == 0, "R5 bus and strobe violations", viol, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule